// File: doc/BRIEF.md
# SD Card SPI-Mode Block Writer

This block sends one write data packet to a memory card that is driven in SPI mode. It sits on top of a byte-exchange SPI port: every exchange shifts one byte out and hands back the byte that was shifted in at the same time. A host pulses `start_i` with a start-token byte. The block then clocks out fill bytes (0xFF) until the card answers 0xFF, which means it is no longer busy. After that it sends the token. For a data token it then sends a block of payload bytes, pulled one per exchange from a valid/ready byte source, followed by a two-byte dummy CRC. Last, it polls for the card's data-response byte.

A stop token carries no payload. The block sends it on its own and finishes at once. The card may return its data-response some bytes late, so the block keeps polling under a timeout counted in ticks. It ignores any byte that does not match the accept pattern. The ticks come from an internal prescaler that divides the clock by `TICK_PERIOD`. The outcome is reported by a one-cycle `done_o` pulse, with `ok_o` set alongside it on success.

Top module: `sd_blk_writer`

## Requirements
- R1: After start, the block sends 0xFF and keeps sending 0xFF while the card returns any other value. The token is sent in the exchange right after the first exchange that returns 0xFF.
- R2: If the card has not returned 0xFF by the end of READY_TICKS ticks (one tick = TICK_PERIOD clocks), the block ends with `done_o`=1 and `ok_o`=0 on the next exchange that completes. The token is never sent.
- R3: A token other than 0xFD (0xFE for a single block, 0xFC for one block of a multi-block write) is followed by exactly BLOCK_BYTES source bytes, in source order and one per exchange. Two 0xFF bytes follow as the dummy CRC.
- R4: Token 0xFD is sent alone. The block ends with `ok_o`=1 once the token exchange completes, with no source handshake, no CRC and no response polling.
- R5: After the CRC, the block ends with `ok_o`=1 on the first received byte whose low five bits equal 0b00101 (byte & 0x1F == 0x05).
- R6: While polling for the response, every received byte that does not match is ignored. The block sends another 0xFF and keeps polling.
- R7: If no matching response arrives within RESP_TICKS ticks of the end of the CRC, the block ends with `done_o`=1 and `ok_o`=0. A rejecting response such as 0x0D therefore ends in failure.
- R8: `done_o` is high for exactly one cycle per operation, and `ok_o` is high only together with `done_o`.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle after `done_o`. A `start_i` seen while busy is ignored and does not change the token in use.
- R10: After reset, `busy_o`, `xfer_req_o`, `src_ready_o`, `done_o` and `ok_o` are all low.
- R11: `xfer_req_o` is a one-cycle pulse. No new request is raised until `xfer_done_i` has returned for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| token_i | input | 8 | Start token, latched with start |
| busy_o | output | 1 | Operation in progress |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Block takes the source byte this cycle |
| xfer_req_o | output | 1 | One-cycle request for a byte exchange |
| xfer_tx_o | output | 8 | Byte to shift out, held from request to completion |
| xfer_done_i | input | 1 | Exchange complete pulse |
| xfer_rx_i | input | 8 | Byte shifted in, valid with `xfer_done_i` |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| ok_o | output | 1 | Success flag, valid with `done_o` |

## Verification
A wrong phase or a wrong byte counter shows on `xfer_tx_o` within one exchange. It appears as a token sent before the card reports ready, a payload one byte too long or too short, or a missing CRC byte. The bench logs every shifted byte and compares the whole stream to the expected packet. A stuck or mis-loaded timeout shows as an end time that falls outside the window set by the tick count, or as a poll count far from the expected number. A response-match error shows as a flipped `ok_o` on the same `done_o` pulse.

// File: rtl/sd_wr_pkg.sv
package sd_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_TOKEN,
    ST_PULL,
    ST_DATA,
    ST_CRC,
    ST_RESP
  } wr_state_e;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
  localparam logic [4:0] RSP_ACCEPT = 5'b00101;

  function automatic logic rsp_accepted(input logic [7:0] b);
    return b[4:0] == RSP_ACCEPT;
  endfunction
endpackage

// File: rtl/sd_wr_timer.sv
// Tick prescaler plus tick countdown, both restarted by load_i.
module sd_wr_timer #(
  parameter int TICK_PERIOD = 1250000,
  parameter int MAX_TICKS   = 50,
  localparam int TW = $clog2(MAX_TICKS + 1),
  localparam int PW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);
  logic [PW-1:0] pre_q;
  logic [TW-1:0] remain_q;
  logic          tick;

  assign tick = (pre_q == PW'(TICK_PERIOD - 1)) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (load_i || pre_q == PW'(TICK_PERIOD - 1)) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (tick && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired_o = (remain_q == '0);
endmodule

// File: rtl/sd_wr_beat_cnt.sv
// Counts completed payload exchanges; last_o flags the final one.
module sd_wr_beat_cnt #(
  parameter int BLOCK_BYTES = 512,
  localparam int CW = $clog2(BLOCK_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(BLOCK_BYTES - 1));
endmodule

// File: rtl/sd_wr_fsm.sv
module sd_wr_fsm
  import sd_wr_pkg::*;
#(
  parameter int READY_TICKS = 50,
  parameter int RESP_TICKS  = 10,
  parameter int TW          = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    token_i,
  output logic          busy_o,
  input  logic          src_valid_i,
  input  logic [7:0]    src_data_i,
  output logic          src_ready_o,
  output logic          xfer_req_o,
  output logic [7:0]    xfer_tx_o,
  input  logic          xfer_done_i,
  input  logic [7:0]    xfer_rx_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  input  logic          tmr_expired_i,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  input  logic          cnt_last_i,
  output logic          done_o,
  output logic          ok_o
);
  wr_state_e  state_q, state_d;
  logic [7:0] tok_q, tok_d;
  logic [7:0] tx_q, tx_d;
  logic       req_q, req_d;
  logic       crc_q, crc_d;
  logic       done_q, done_d;
  logic       ok_q, ok_d;

  always_comb begin
    state_d     = state_q;
    tok_d       = tok_q;
    tx_d        = tx_q;
    req_d       = 1'b0;
    crc_d       = crc_q;
    done_d      = 1'b0;
    ok_d        = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = TW'(READY_TICKS);
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    src_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          tok_d      = token_i;
          tmr_load_o = 1'b1;
          req_d      = 1'b1;
          tx_d       = FILL_BYTE;
          state_d    = ST_READY;
        end
      end
      ST_READY: begin
        if (xfer_done_i) begin
          if (xfer_rx_i == FILL_BYTE) begin
            req_d   = 1'b1;
            tx_d    = tok_q;
            state_d = ST_TOKEN;
          end else if (tmr_expired_i) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            req_d = 1'b1;
            tx_d  = FILL_BYTE;
          end
        end
      end
      ST_TOKEN: begin
        if (xfer_done_i) begin
          if (tok_q == TOK_STOP) begin
            done_d  = 1'b1;
            ok_d    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_clr_o = 1'b1;
            state_d   = ST_PULL;
          end
        end
      end
      ST_PULL: begin
        src_ready_o = 1'b1;
        if (src_valid_i) begin
          req_d   = 1'b1;
          tx_d    = src_data_i;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (xfer_done_i) begin
          if (cnt_last_i) begin
            req_d   = 1'b1;
            tx_d    = FILL_BYTE;
            crc_d   = 1'b0;
            state_d = ST_CRC;
          end else begin
            cnt_inc_o = 1'b1;
            state_d   = ST_PULL;
          end
        end
      end
      ST_CRC: begin
        if (xfer_done_i) begin
          req_d = 1'b1;
          tx_d  = FILL_BYTE;
          if (crc_q) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(RESP_TICKS);
            state_d    = ST_RESP;
          end else begin
            crc_d = 1'b1;
          end
        end
      end
      ST_RESP: begin
        if (xfer_done_i) begin
          if (rsp_accepted(xfer_rx_i)) begin
            done_d  = 1'b1;
            ok_d    = 1'b1;
            state_d = ST_IDLE;
          end else if (tmr_expired_i) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            req_d = 1'b1;
            tx_d  = FILL_BYTE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tok_q   <= '0;
      tx_q    <= FILL_BYTE;
      req_q   <= 1'b0;
      crc_q   <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tok_q   <= tok_d;
      tx_q    <= tx_d;
      req_q   <= req_d;
      crc_q   <= crc_d;
      done_q  <= done_d;
      ok_q    <= ok_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign xfer_req_o = req_q;
  assign xfer_tx_o  = tx_q;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
endmodule

// File: rtl/sd_blk_writer.sv
module sd_blk_writer #(
  parameter int BLOCK_BYTES = 512,
  parameter int TICK_PERIOD = 1250000,
  parameter int READY_TICKS = 50,
  parameter int RESP_TICKS  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] token_i,
  output logic       busy_o,
  input  logic       src_valid_i,
  input  logic [7:0] src_data_i,
  output logic       src_ready_o,
  output logic       xfer_req_o,
  output logic [7:0] xfer_tx_o,
  input  logic       xfer_done_i,
  input  logic [7:0] xfer_rx_i,
  output logic       done_o,
  output logic       ok_o
);
  localparam int MAX_T = (READY_TICKS > RESP_TICKS) ? READY_TICKS : RESP_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          cnt_clr, cnt_inc, cnt_last;

  sd_wr_timer #(
    .TICK_PERIOD(TICK_PERIOD),
    .MAX_TICKS  (MAX_T)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_expired)
  );

  sd_wr_beat_cnt #(
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_beats (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .last_o(cnt_last)
  );

  sd_wr_fsm #(
    .READY_TICKS(READY_TICKS),
    .RESP_TICKS (RESP_TICKS),
    .TW         (TW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .token_i      (token_i),
    .busy_o       (busy_o),
    .src_valid_i  (src_valid_i),
    .src_data_i   (src_data_i),
    .src_ready_o  (src_ready_o),
    .xfer_req_o   (xfer_req_o),
    .xfer_tx_o    (xfer_tx_o),
    .xfer_done_i  (xfer_done_i),
    .xfer_rx_i    (xfer_rx_i),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .tmr_expired_i(tmr_expired),
    .cnt_clr_o    (cnt_clr),
    .cnt_inc_o    (cnt_inc),
    .cnt_last_i   (cnt_last),
    .done_o       (done_o),
    .ok_o         (ok_o)
  );
endmodule

// File: rtl/sd_wr_checker.sv
module sd_wr_checker #(
  parameter int BLOCK_BYTES = 512,
  localparam int BW = $clog2(BLOCK_BYTES + 1) + 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] token_i,
  input logic       busy_o,
  input logic       src_valid_i,
  input logic       src_ready_o,
  input logic       xfer_req_o,
  input logic       xfer_done_i,
  input logic       done_o,
  input logic       ok_o
);
  logic          out_q;
  logic [7:0]    tok_q;
  logic [BW-1:0] beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      tok_q   <= '0;
      beats_q <= '0;
    end else begin
      if (xfer_req_o) out_q <= 1'b1;
      else if (xfer_done_i) out_q <= 1'b0;
      if (start_i && !busy_o) begin
        tok_q   <= token_i;
        beats_q <= '0;
      end else if (src_valid_i && src_ready_o) begin
        beats_q <= beats_q + 1'b1;
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ok_qual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> done_o);
  p_req_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);
  p_one_outstanding_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> !out_q);
  p_pull_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> busy_o);
  p_block_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o && tok_q != 8'hFD) |-> (beats_q == BW'(BLOCK_BYTES)));
  p_stop_alone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tok_q == 8'hFD) |-> (beats_q == '0));
  p_idle_after_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!xfer_req_o && !src_ready_o));
endmodule

bind sd_blk_writer sd_wr_checker #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .token_i    (token_i),
  .busy_o     (busy_o),
  .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o),
  .xfer_req_o (xfer_req_o),
  .xfer_done_i(xfer_done_i),
  .done_o     (done_o),
  .ok_o       (ok_o)
);

// File: tb/tb_sd_blk_writer.sv
`timescale 1ns/1ps
module tb_sd_blk_writer;
  localparam int BLK = 512;
  localparam int TP  = 20;
  localparam int RDY = 50;
  localparam int RSP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] token = 8'h00;
  logic       busy, src_valid, src_ready, xfer_req, xfer_done, done, ok;
  logic [7:0] src_data, xfer_tx, xfer_rx;

  always #4 clk = ~clk;

  sd_blk_writer #(
    .BLOCK_BYTES(BLK), .TICK_PERIOD(TP), .READY_TICKS(RDY), .RESP_TICKS(RSP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .token_i(token), .busy_o(busy),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .xfer_req_o(xfer_req), .xfer_tx_o(xfer_tx), .xfer_done_i(xfer_done),
    .xfer_rx_i(xfer_rx), .done_o(done), .ok_o(ok)
  );

  // scenario configuration, written by tasks only
  int         cfg_busy = 0;
  int         cfg_rdel = 0;
  logic [7:0] cfg_rval = 8'h05;
  logic [7:0] cfg_seed = 8'h00;
  logic       cfg_gap  = 1'b0;

  int total = 0;
  int bad   = 0;

  // card + source model
  logic [7:0] tx_log [0:1023];
  int         log_n = 0;
  int         ph = 0;
  int         busy_left = 0;
  int         resp_left = 0;
  int         dcnt = 0;
  int         pend = 0;
  logic [7:0] rx_hold = 8'hFF;
  int         idx = 0;
  int         cyc = 0;
  int         done_seen = 0;

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'((i * 13) + int'(s));
  endfunction

  assign src_data  = pat(idx, cfg_seed);
  assign src_valid = !(cfg_gap && (cyc % 4 == 1));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    xfer_done <= 1'b0;
    if (done) done_seen <= done_seen + 1;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        xfer_done <= 1'b1;
        xfer_rx   <= rx_hold;
      end
    end
    if (src_valid && src_ready) idx <= idx + 1;
    if (start && !busy) begin
      ph <= 0; busy_left <= cfg_busy; resp_left <= cfg_rdel;
      log_n <= 0; idx <= 0; dcnt <= 0; done_seen <= 0;
    end else if (xfer_req) begin
      pend <= 3;
      if (log_n < 1024) tx_log[log_n] <= xfer_tx;
      log_n <= log_n + 1;
      case (ph)
        0: if (busy_left > 0) begin rx_hold <= 8'h00; busy_left <= busy_left - 1; end
           else begin rx_hold <= 8'hFF; ph <= 1; end
        1: begin rx_hold <= 8'hFF; ph <= (xfer_tx == 8'hFD) ? 4 : 2; dcnt <= 0; end
        2: begin rx_hold <= 8'hFF; dcnt <= dcnt + 1; if (dcnt == BLK + 1) ph <= 3; end
        3: if (resp_left > 0) begin
             rx_hold <= resp_left[0] ? 8'hFF : 8'h0B; resp_left <= resp_left - 1;
           end else begin rx_hold <= cfg_rval; ph <= 4; end
        default: rx_hold <= 8'hFF;
      endcase
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one operation; poke sends a stray start while busy
  task automatic run_op(input logic [7:0] tok, input bit poke,
                        output bit got_ok, output int cycles, output bit hung);
    @(negedge clk);
    start = 1'b1; token = tok;
    @(negedge clk);
    start = 1'b0; token = 8'h00;
    cycles = 1;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1; token = 8'hFD;
      @(negedge clk);
      start = 1'b0;
      cycles += 11;
    end
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    hung   = !done;
    got_ok = ok;
    @(negedge clk);
    chk(!done, "R8 done width", int'(done), 0);
    chk(!busy, "R9 idle after done", int'(busy), 0);
  endtask

  task automatic check_data(input int base, input string tag);
    int errs = 0;
    for (int i = 0; i < BLK; i++)
      if (tx_log[base + i] !== pat(i, cfg_seed)) errs++;
    chk(errs == 0, tag, errs, 0);
    chk(tx_log[base + BLK] == 8'hFF && tx_log[base + BLK + 1] == 8'hFF,
        "R3 dummy crc", int'(tx_log[base + BLK]), 255);
  endtask

  task automatic t_reset();
    chk(!busy && !xfer_req && !src_ready && !done && !ok, "R10 reset state",
        int'({busy, xfer_req, src_ready, done, ok}), 0);
  endtask

  task automatic t_single();
    bit o, h; int c; int ff = 0;
    cfg_busy = 3; cfg_rdel = 0; cfg_rval = 8'hE5; cfg_seed = 8'h21; cfg_gap = 1'b0;
    run_op(8'hFE, 1'b0, o, c, h);
    chk(!h && o, "R5 accept 0xE5", int'(o), 1);
    for (int i = 0; i < 4; i++) if (tx_log[i] == 8'hFF) ff++;
    chk(ff == 4, "R1 fill while busy", ff, 4);
    chk(tx_log[4] == 8'hFE, "R1 token after ready", int'(tx_log[4]), 254);
    check_data(5, "R3 single data");
    chk(log_n == 520, "R3 exchange count", log_n, 520);
    chk(done_seen == 1, "R8 one done", done_seen, 1);
  endtask

  task automatic t_multi_late();
    bit o, h; int c;
    cfg_busy = 0; cfg_rdel = 6; cfg_rval = 8'h05; cfg_seed = 8'h5A; cfg_gap = 1'b1;
    run_op(8'hFC, 1'b1, o, c, h);
    chk(!h && o, "R6 late response ok", int'(o), 1);
    chk(tx_log[1] == 8'hFC, "R9 token kept", int'(tx_log[1]), 252);
    check_data(2, "R3 multi data gaps");
    chk(log_n == 523, "R6 poll count", log_n, 523);
    chk(done_seen == 1, "R9 stray start ignored", done_seen, 1);
  endtask

  task automatic t_stop();
    bit o, h; int c;
    cfg_busy = 2; cfg_rdel = 0; cfg_rval = 8'h05; cfg_seed = 8'h00; cfg_gap = 1'b0;
    run_op(8'hFD, 1'b0, o, c, h);
    chk(!h && o, "R4 stop ok", int'(o), 1);
    chk(log_n == 4 && tx_log[3] == 8'hFD, "R4 stop alone", log_n, 4);
    chk(idx == 0, "R4 no source pull", idx, 0);
  endtask

  task automatic t_ready_timeout();
    bit o, h; int c; int tokseen = 0;
    cfg_busy = 100000; cfg_rdel = 0; cfg_rval = 8'h05; cfg_gap = 1'b0;
    run_op(8'hFE, 1'b0, o, c, h);
    chk(!h && !o, "R2 ready timeout error", int'(o), 0);
    chk(c >= RDY * TP - 5 && c <= RDY * TP + 30, "R2 timeout window", c, RDY * TP);
    for (int i = 0; i < log_n && i < 1024; i++) if (tx_log[i] != 8'hFF) tokseen++;
    chk(tokseen == 0, "R2 token not sent", tokseen, 0);
  endtask

  task automatic t_resp_reject();
    bit o, h; int c; int polls;
    cfg_busy = 0; cfg_rdel = 0; cfg_rval = 8'h0D; cfg_seed = 8'h33; cfg_gap = 1'b0;
    run_op(8'hFE, 1'b0, o, c, h);
    chk(!h && !o, "R7 reject then timeout", int'(o), 0);
    polls = log_n - 516;
    chk(polls >= 30 && polls <= 50, "R7 poll window", polls, 40);
  endtask

  task automatic t_back_to_back();
    bit o, h; int c;
    cfg_busy = 0; cfg_rdel = 1; cfg_rval = 8'h25; cfg_seed = 8'h99; cfg_gap = 1'b0;
    run_op(8'hFE, 1'b0, o, c, h);
    chk(!h && o, "R5 immediate ready ok", int'(o), 1);
    chk(tx_log[0] == 8'hFF && tx_log[1] == 8'hFE, "R1 no-wait token", int'(tx_log[1]), 254);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_multi_late();
    t_stop();
    t_ready_timeout();
    t_resp_reject();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule